// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Register Port

This block gives a host processor byte-wide access to a bank of 32 eight-bit registers. Two static select pins configure it. The first chooses how the address arrives: either on dedicated address pins, or on the shared data bus, where it is latched by an address-latch strobe. The second chooses the strobe style: separate active-low read and write strobes, or one active-low data strobe qualified by a read/write level. An active-low chip select gates every access.

All host pins are asynchronous to the internal clock. Chip select and the three strobes each pass through a two-flop synchronizer. A four-state machine then turns the synchronized strobes into bus-drive and register-commit actions:
- The states are IDLE, READ, WRITE and COMMIT.
- IDLE goes to READ on an active read and to WRITE on an active write.
- READ returns to IDLE when the read ends.
- WRITE goes to COMMIT when the write strobe is released.
- COMMIT always returns to IDLE after one cycle.

The data bus is split at the pad into an input, an output and an output enable. The enable is high only in READ.

Location 0 holds event-status bits. Each bit is set by a one-cycle pulse on the synchronous event input, and the host clears it by writing a one to it. Location 1 holds the matching mask. The active-low interrupt, which is open-drain at the pad, is low whenever a status bit and its mask bit are both one. An active-low reset clears every location.

Top module: `hbus_port`

## Requirements
- R1: While reset is low, and after it is released, every location reads 0x00, the output enable is 0 and irq_n is 1.
- R2: With mode_direct=1 and mode_moto=0, a write uses the address on the addr pins and the data on dq_in, and commits on the rising edge of strb_b (write strobe). A later read with strb_a (read strobe) low returns that byte.
- R3: With mode_direct=0, the address is bits [4:0] of dq_in captured at the rising edge of ale, and the addr pins are ignored.
- R4: With mode_moto=1, strb_a is the active-low data strobe and strb_b is read/write (1 = read). A write commits on the rising edge of strb_a while strb_b is 0.
- R5: While cs_n is 1, strobe activity neither writes any location nor enables the data output.
- R6: dq_oe is 1 only during a selected read. It is 0 when idle, during writes, and after the read strobe is released.
- R7: A pulse on ev_in[i] sets bit i of location 0. Writing a byte to location 0 clears exactly the bits that are one in that byte, and zero bits leave the status unchanged.
- R8: irq_n is 0 exactly when (location 0 AND location 1) is nonzero. A status bit whose mask bit is 0 does not pull it low.
- R9: A write takes effect only after its strobe is released. While the write strobe is held low, the target location (and so irq_n) keeps its old value.
- R10: Pulsing rst_n low after registers have been written returns every location to 0x00 and irq_n to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_direct | input | 1 | 1: address on addr pins, 0: address multiplexed on data bus |
| mode_moto | input | 1 | 1: data strobe plus read/write level, 0: separate read/write strobes |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address latch strobe (multiplexed mode), rising edge latches |
| strb_a | input | 1 | Read strobe (separate mode) or data strobe (combined mode), active low |
| strb_b | input | 1 | Write strobe (separate mode) or read/write level (combined mode) |
| addr | input | 5 | Dedicated address pins |
| dq_in | input | 8 | Data bus input from pad |
| dq_out | output | 8 | Read data to pad |
| dq_oe | output | 1 | Pad output enable for the data bus |
| ev_in | input | 8 | Synchronous one-cycle status event pulses |
| irq_n | output | 1 | Active-low interrupt, open-drain at the pad |

## Verification
The hardest case to reach is the window between a write strobe going low and its commit, in which the target location must not yet have changed (R9). Reading back cannot see this window, because a read cannot overlap the write. The bench therefore first sets a status bit while its mask is zero. It then writes that mask bit and holds the write strobe low for several cycles, checking that irq_n stays high. It releases the strobe and checks that irq_n falls a fixed number of cycles later. The multiplexed-address case is exercised with the addr pins deliberately pointing at a different location, so that a wrong address source would corrupt a known register.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_COMMIT
    } hbus_state_e;

    localparam int STATUS_IDX = 0;
    localparam int MASK_IDX   = 1;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= RST_VAL[g];
                s2 <= RST_VAL[g];
            end else begin
                s1 <= d[g];
                s2 <= s1;
            end
        end
        assign q[g] = s2;
    end
endmodule

// File: rtl/hbus_addr.sv
module hbus_addr #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_direct,
    input  logic          ale_s,
    input  logic [DW-1:0] dq_in,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] addr_eff
);
    logic          ale_d;
    logic [AW-1:0] mux_q;
    logic [AW-1:0] dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_d <= 1'b0;
            mux_q <= '0;
            dir_q <= '0;
        end else begin
            ale_d <= ale_s;
            dir_q <= addr;
            if (ale_s && !ale_d)
                mux_q <= dq_in[AW-1:0];
        end
    end

    assign addr_eff = mode_direct ? dir_q : mux_q;
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_moto,
    input  logic          cs_s,
    input  logic          sa_s,
    input  logic          sb_s,
    input  logic [AW-1:0] addr_eff,
    input  logic [DW-1:0] dq_in,
    output logic          rd_act,
    output logic          wr_act,
    output logic          dq_oe,
    output logic          reg_we,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    hbus_state_e state, state_n;

    // strobe decode per bus style
    assign rd_act = !cs_s && (mode_moto ? (!sa_s && sb_s)  : !sa_s);
    assign wr_act = !cs_s && (mode_moto ? (!sa_s && !sb_s) : !sb_s);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_act)      state_n = ST_READ;
                else if (wr_act) state_n = ST_WRITE;
            end
            ST_READ:   if (!rd_act) state_n = ST_IDLE;
            ST_WRITE:  if (!wr_act) state_n = ST_COMMIT;
            ST_COMMIT: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        dq_oe  = 1'b0;
        reg_we = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_READ:   dq_oe  = 1'b1;
            ST_WRITE:  ;
            ST_COMMIT: reg_we = 1'b1;
            default:   ;
        endcase
    end

    // hold address and data sampled while the write strobe is active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (state_n == ST_WRITE) begin
            wr_addr <= addr_eff;
            wr_data <= dq_in;
        end
    end
endmodule

// File: rtl/hbus_regs.sv
module hbus_regs
    import hbus_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    input  logic [DW-1:0] ev_in,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] status_q,
    output logic [DW-1:0] mask_q
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_loc
        if (g == STATUS_IDX) begin : g_status
            logic [DW-1:0] clr;
            assign clr = (we && waddr == AW'(g)) ? wdata : '0;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mem[g] <= '0;
                else        mem[g] <= (mem[g] & ~clr) | ev_in;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                        mem[g] <= '0;
                else if (we && waddr == AW'(g))    mem[g] <= wdata;
            end
        end
    end

    assign rdata    = mem[raddr];
    assign status_q = mem[STATUS_IDX];
    assign mask_q   = mem[MASK_IDX];
endmodule

// File: rtl/hbus_port.sv
module hbus_port #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_direct,
    input  logic          mode_moto,
    input  logic          cs_n,
    input  logic          ale,
    input  logic          strb_a,
    input  logic          strb_b,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    input  logic [DW-1:0] ev_in,
    output logic          irq_n
);
    logic          cs_s, ale_s, sa_s, sb_s;
    logic [AW-1:0] addr_eff;
    logic          rd_act, wr_act, reg_we;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] status_q, mask_q;

    hbus_sync #(.W(4), .RST_VAL(4'b1011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, ale, strb_a, strb_b}),
        .q     ({cs_s, ale_s, sa_s, sb_s})
    );

    hbus_addr #(.AW(AW), .DW(DW)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_direct (mode_direct),
        .ale_s       (ale_s),
        .dq_in       (dq_in),
        .addr        (addr),
        .addr_eff    (addr_eff)
    );

    hbus_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_moto (mode_moto),
        .cs_s      (cs_s),
        .sa_s      (sa_s),
        .sb_s      (sb_s),
        .addr_eff  (addr_eff),
        .dq_in     (dq_in),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .dq_oe     (dq_oe),
        .reg_we    (reg_we),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    hbus_regs #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .waddr    (wr_addr),
        .wdata    (wr_data),
        .raddr    (addr_eff),
        .ev_in    (ev_in),
        .rdata    (dq_out),
        .status_q (status_q),
        .mask_q   (mask_q)
    );

    assign irq_n = ~|(status_q & mask_q);
endmodule

// File: rtl/hbus_port_chk.sv
module hbus_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_s,
    input logic          rd_act,
    input logic          wr_act,
    input logic          reg_we,
    input logic [DW-1:0] ev_in,
    input logic [DW-1:0] mask_q,
    input logic          irq_n,
    input logic          dq_oe
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (irq_n && !dq_oe);
        end
    end

    assert_unselected_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !dq_oe);

    assert_drive_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(rd_act));

    assert_irq_follows_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(ev_in & mask_q)) && !reg_we) |=> !irq_n);

    assert_commit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_commit_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !$past(wr_act));
endmodule

bind hbus_port hbus_port_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_s   (cs_s),
    .rd_act (rd_act),
    .wr_act (wr_act),
    .reg_we (reg_we),
    .ev_in  (ev_in),
    .mask_q (mask_q),
    .irq_n  (irq_n),
    .dq_oe  (dq_oe)
);

// File: tb/hbus_port_tb.sv
module hbus_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_direct = 1'b1;
    logic       mode_moto = 1'b0;
    logic       cs_n = 1'b1;
    logic       ale = 1'b0;
    logic       strb_a = 1'b1;
    logic       strb_b = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic [7:0] ev_in = '0;
    logic       irq_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hbus_port u_dut (
        .clk(clk), .rst_n(rst_n), .mode_direct(mode_direct), .mode_moto(mode_moto),
        .cs_n(cs_n), .ale(ale), .strb_a(strb_a), .strb_b(strb_b), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .ev_in(ev_in), .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_addr(input logic [4:0] a);
        if (mode_direct) addr = a;
        else begin
            dq_in = {3'b000, a};
            ale = 1'b1;
            cyc(4);
            ale = 1'b0;
            cyc(2);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d, input logic sel_n);
        set_addr(a);
        dq_in = d;
        cs_n = sel_n;
        if (mode_moto) strb_b = 1'b0;
        cyc(1);
        if (mode_moto) strb_a = 1'b0; else strb_b = 1'b0;
        cyc(4);
        if (mode_moto) strb_a = 1'b1; else strb_b = 1'b1;
        cyc(5);
        cs_n = 1'b1;
        strb_b = 1'b1;
        cyc(2);
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [7:0] exp, input string tag);
        set_addr(a);
        cs_n = 1'b0;
        cyc(1);
        strb_a = 1'b0;
        cyc(5);
        check({tag, " oe"}, {7'd0, dq_oe}, 8'h01);
        check({tag, " data"}, dq_out, exp);
        strb_a = 1'b1;
        cyc(4);
        check("R6 oe after read", {7'd0, dq_oe}, 8'h00);
        cs_n = 1'b1;
        cyc(2);
    endtask

    task automatic pulse_ev(input logic [7:0] v);
        ev_in = v;
        cyc(1);
        ev_in = '0;
        cyc(1);
    endtask

    task automatic t_reset();
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 oe", {7'd0, dq_oe}, 8'h00);
        bus_read(5'd0, 8'h00, "R1 loc0");
        bus_read(5'd1, 8'h00, "R1 loc1");
        bus_read(5'd31, 8'h00, "R1 loc31");
    endtask

    task automatic t_intel_direct();
        bus_write(5'd5, 8'hA5, 1'b0);
        bus_write(5'd31, 8'h3C, 1'b0);
        bus_read(5'd5, 8'hA5, "R2 loc5");
        bus_read(5'd31, 8'h3C, "R2 loc31");
    endtask

    task automatic t_mux();
        mode_direct = 1'b0;
        addr = 5'd5;               // decoy: must be ignored (R3)
        bus_write(5'd9, 8'h5A, 1'b0);
        bus_read(5'd9, 8'h5A, "R3 loc9");
        bus_read(5'd5, 8'hA5, "R3 decoy loc5");
        mode_direct = 1'b1;
    endtask

    task automatic t_moto();
        mode_moto = 1'b1;
        bus_write(5'd7, 8'hC3, 1'b0);
        bus_read(5'd7, 8'hC3, "R4 loc7");
        bus_read(5'd5, 8'hA5, "R4 loc5");
        mode_moto = 1'b0;
    endtask

    task automatic t_cs();
        bus_write(5'd5, 8'hFF, 1'b1);
        addr = 5'd5;
        strb_a = 1'b0;
        cyc(6);
        check("R5 oe unselected", {7'd0, dq_oe}, 8'h00);
        strb_a = 1'b1;
        cyc(3);
        bus_read(5'd5, 8'hA5, "R5 loc5 kept");
    endtask

    task automatic t_hiz();
        check("R6 oe idle", {7'd0, dq_oe}, 8'h00);
        addr = 5'd12;
        dq_in = 8'h11;
        cs_n = 1'b0;
        cyc(1);
        strb_b = 1'b0;
        cyc(5);
        check("R6 oe during write", {7'd0, dq_oe}, 8'h00);
        strb_b = 1'b1;
        cyc(5);
        cs_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_status();
        pulse_ev(8'h05);
        bus_read(5'd0, 8'h05, "R7 set");
        bus_write(5'd0, 8'h00, 1'b0);
        bus_read(5'd0, 8'h05, "R7 zero write");
        bus_write(5'd0, 8'h01, 1'b0);
        bus_read(5'd0, 8'h04, "R7 clear bit0");
        bus_write(5'd0, 8'h04, 1'b0);
        bus_read(5'd0, 8'h00, "R7 clear bit2");
    endtask

    task automatic t_irq();
        pulse_ev(8'h02);
        check("R8 masked irq_n", {7'd0, irq_n}, 8'h01);
        bus_write(5'd1, 8'h02, 1'b0);
        check("R8 enabled irq_n", {7'd0, irq_n}, 8'h00);
        bus_write(5'd0, 8'h02, 1'b0);
        check("R8 cleared irq_n", {7'd0, irq_n}, 8'h01);
        pulse_ev(8'h08);
        check("R8 other bit irq_n", {7'd0, irq_n}, 8'h01);
        bus_write(5'd0, 8'h08, 1'b0);
    endtask

    task automatic t_commit();
        bus_write(5'd1, 8'h00, 1'b0);
        pulse_ev(8'h02);
        check("R9 pre irq_n", {7'd0, irq_n}, 8'h01);
        addr = 5'd1;
        dq_in = 8'h02;
        cs_n = 1'b0;
        cyc(1);
        strb_b = 1'b0;
        cyc(8);
        check("R9 held strobe irq_n", {7'd0, irq_n}, 8'h01);
        strb_b = 1'b1;
        cyc(5);
        check("R9 after release irq_n", {7'd0, irq_n}, 8'h00);
        cs_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_hwreset();
        rst_n = 1'b0;
        cyc(2);
        check("R10 irq_n in reset", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        cyc(3);
        bus_read(5'd5, 8'h00, "R10 loc5");
        bus_read(5'd7, 8'h00, "R10 loc7");
        bus_read(5'd1, 8'h00, "R10 loc1");
        bus_read(5'd0, 8'h00, "R10 loc0");
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_intel_direct();
        t_mux();
        t_moto();
        t_cs();
        t_hiz();
        t_status();
        t_irq();
        t_commit();
        t_hwreset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule